// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the eight event flags and eight enable bits that belong to a group of 8-bit timer/counters, and turns them into interrupt requests for a processor core. Timer0 and timer1 events come in as single-cycle pulses on `evt_lo`. Timer2 is modelled inside the block as a small counter. The counter either wraps upward, or in PWM mode runs up and then back down, and it produces the timer2 compare and overflow events itself.

Software writes the enable register directly. It clears flags by writing ones through the same write port. When the core takes a vector it pulses the matching `ack` bit, and that flag is cleared by hardware. A request exists for a source when the global enable, the source's enable bit and its flag are all one. The block presents the highest-priority request as a one-hot `pend` word and holds it until that source is acknowledged.

Top module: `tif_ctrl`

## Requirements
- R1: A synchronous reset makes `flags`, `mask`, `pend` and `t2_count` all zero.
- R2: The flag bit map is: bit 7 timer2 compare, bit 6 timer2 overflow, bit 5 timer1 capture, bit 4 timer1 compare A, bit 3 timer1 compare B, bit 2 timer1 overflow, bit 1 timer0 compare, bit 0 timer0 overflow. A pulse on `evt_lo[i]` sets flag i at the next clock edge.
- R3: A write with `wr_en`=1 and `wr_sel`=0 clears every flag whose `wr_data` bit is one. Flags whose `wr_data` bit is zero keep their value.
- R4: `ack[i]`=1 clears flag i at the next clock edge.
- R5: When a set event and a clear (a written one or an `ack`) reach the same flag in the same cycle, the flag ends up one.
- R6: A write with `wr_en`=1 and `wr_sel`=1 loads `mask` from `wr_data` at the next edge and leaves `flags` unchanged. Mask bit i enables flag i.
- R7: Bit i can become pending only when `gie`, `mask[i]` and `flags[i]` are all one. With `gie`=0 or `mask[i]`=0, `pend` stays zero for that source.
- R8: `pend` is one-hot or zero. When it is empty and requests exist, it loads the highest requesting bit (bit 7 highest) at the next edge.
- R9: A nonzero `pend` keeps its value, even when new higher requests arrive, until `ack` has a one at its bit. At that edge it becomes zero.
- R10: With `t2_pwm`=0, each `t2_tick` increments `t2_count`, and 0xFF wraps to 0x00. The tick that wraps it sets flag 6.
- R11: With `t2_pwm`=1, the count climbs to 0xFF, then falls to 0x00, then climbs again. Flag 6 is set only by the tick that turns the count around at 0x00 (0x00 to 0x01). Reaching the top or arriving at zero does not set it.
- R12: Flag 7 is set by the tick whose new count equals `t2_cmp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lo | input | 6 | Event pulses for flags 5..0 |
| t2_tick | input | 1 | Timer2 count enable for one step |
| t2_pwm | input | 1 | Timer2 up/down (PWM) mode |
| t2_cmp | input | 8 | Timer2 compare value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = flag register (write one to clear), 1 = mask register |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| ack | input | 8 | Vector-taken acknowledge, one bit per source |
| flags | output | 8 | Flag register |
| mask | output | 8 | Interrupt enable register |
| pend | output | 8 | One-hot pending interrupt |
| t2_count | output | 8 | Timer2 count |

## Verification
Flags, mask and count all change at the first rising edge after the cycle that carries the pulse, write, tick or acknowledge. An empty `pend` fills one edge after the request condition holds. After an acknowledge, `pend` drops at the first edge, and the next source appears at the second edge. The bench drives every input at the falling edge and compares all four outputs with its behavioural model at the next falling edge, so each result is sampled exactly one edge after the stimulus. The directed checks are placed at those same falling edges.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int NFLAG = 8;
  localparam int NLO   = NFLAG - 2;
  localparam int B_T2_CMP = NFLAG - 1;
  localparam int B_T2_OVF = NFLAG - 2;

  typedef enum logic {SEL_FLAG = 1'b0, SEL_MASK = 1'b1} wr_sel_e;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/tif_updown_cnt.sv
module tif_updown_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         pwm,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic         ev_ovf,
  output logic         ev_cmp
);
  import tif_pkg::*;

  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] CMIN = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  dir_e         dir_q, dir_nx;
  logic [W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = count;
    dir_nx = dir_q;
    ev_ovf = 1'b0;
    if (!pwm) dir_nx = DIR_UP;
    if (tick) begin
      if (!pwm) begin
        cnt_nx = count + ONE;
        ev_ovf = (count == CMAX);
      end else if (dir_q == DIR_UP) begin
        if (count == CMAX) begin
          dir_nx = DIR_DOWN;
          cnt_nx = count - ONE;
        end else begin
          cnt_nx = count + ONE;
        end
      end else begin
        if (count == CMIN) begin
          dir_nx = DIR_UP;
          cnt_nx = count + ONE;
          ev_ovf = 1'b1;
        end else begin
          cnt_nx = count - ONE;
        end
      end
    end
    ev_cmp = tick && (cnt_nx == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      dir_q <= DIR_UP;
    end else begin
      count <= cnt_nx;
      dir_q <= dir_nx;
    end
  end
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_wr,
  input  logic [N-1:0] clr_ack,
  output logic [N-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)            flags[g] <= 1'b0;
        else if (set_ev[g]) flags[g] <= 1'b1;
        else if (clr_wr[g] || clr_ack[g]) flags[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/tif_pend_arb.sv
module tif_pend_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  logic [N-1:0] pick;
  logic         found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (pend != '0) begin
      if ((ack & pend) != '0) pend <= '0;
    end else begin
      pend <= pick;
    end
  end
endmodule

// File: rtl/tif_ctrl.sv
module tif_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [tif_pkg::NLO-1:0]   evt_lo,
  input  logic                      t2_tick,
  input  logic                      t2_pwm,
  input  logic [CNT_W-1:0]          t2_cmp,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [tif_pkg::NFLAG-1:0] wr_data,
  input  logic                      gie,
  input  logic [tif_pkg::NFLAG-1:0] ack,
  output logic [tif_pkg::NFLAG-1:0] flags,
  output logic [tif_pkg::NFLAG-1:0] mask,
  output logic [tif_pkg::NFLAG-1:0] pend,
  output logic [CNT_W-1:0]          t2_count
);
  import tif_pkg::*;

  logic             ev_ovf, ev_cmp;
  logic [NFLAG-1:0] set_ev, clr_wr, req;
  logic             wr_flag, wr_mask;

  assign wr_flag = wr_en && (wr_sel_e'(wr_sel) == SEL_FLAG);
  assign wr_mask = wr_en && (wr_sel_e'(wr_sel) == SEL_MASK);

  tif_updown_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (t2_tick),
    .pwm     (t2_pwm),
    .cmp_val (t2_cmp),
    .count   (t2_count),
    .ev_ovf  (ev_ovf),
    .ev_cmp  (ev_cmp)
  );

  always_comb begin
    set_ev             = '0;
    set_ev[NLO-1:0]    = evt_lo;
    set_ev[B_T2_OVF]   = ev_ovf;
    set_ev[B_T2_CMP]   = ev_cmp;
  end

  assign clr_wr = wr_flag ? wr_data : '0;

  tif_flag_bank #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (set_ev),
    .clr_wr  (clr_wr),
    .clr_ack (ack),
    .flags   (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (wr_mask) mask <= wr_data;
  end

  assign req = gie ? (flags & mask) : '0;

  tif_pend_arb #(.N(NFLAG)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .ack  (ack),
    .pend (pend)
  );
endmodule

// File: rtl/tif_ctrl_chk.sv
module tif_ctrl_chk (
  input logic                      clk,
  input logic                      rst,
  input logic [tif_pkg::NLO-1:0]   evt_lo,
  input logic                      wr_en,
  input logic                      wr_sel,
  input logic [tif_pkg::NFLAG-1:0] wr_data,
  input logic                      gie,
  input logic [tif_pkg::NFLAG-1:0] ack,
  input logic [tif_pkg::NFLAG-1:0] flags,
  input logic [tif_pkg::NFLAG-1:0] mask,
  input logic [tif_pkg::NFLAG-1:0] pend
);
  import tif_pkg::*;

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == '0 && mask == '0 && pend == '0));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (|(ack[NLO-1:0] & ~evt_lo)) |=>
      ((flags[NLO-1:0] & $past(ack[NLO-1:0] & ~evt_lo)) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_lo) |=> ((flags[NLO-1:0] & $past(evt_lo)) == $past(evt_lo)));

  a_r6_mask_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (mask == $past(wr_data)));

  a_r7_pend_gated: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (pend == '0 ||
      ($past(gie) && (($past(flags & mask) & pend) != '0))));

  a_r8_pend_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend));

  a_r9_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend != '0 && (ack & pend) == '0) |=> (pend == $past(pend)));
endmodule

bind tif_ctrl tif_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .evt_lo  (evt_lo),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .gie     (gie),
  .ack     (ack),
  .flags   (flags),
  .mask    (mask),
  .pend    (pend)
);

// File: tb/tif_ctrl_tb.sv
`timescale 1ns/1ps
module tif_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt_lo = '0;
  logic       t2_tick = 1'b0, t2_pwm = 1'b0;
  logic [7:0] t2_cmp = 8'h80;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       gie = 1'b0;
  logic [7:0] ack = '0;
  logic [7:0] flags, mask, pend, t2_count;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  bit [7:0] m_flags, m_mask, m_pend;
  int       m_cnt;
  bit       m_down;

  always #2 clk = ~clk;

  tif_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_lo(evt_lo), .t2_tick(t2_tick), .t2_pwm(t2_pwm),
    .t2_cmp(t2_cmp), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gie(gie), .ack(ack), .flags(flags), .mask(mask), .pend(pend),
    .t2_count(t2_count)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [7:0] top_bit(input bit [7:0] r);
    for (int i = 7; i >= 0; i--) if (r[i]) return 8'(1 << i);
    return 8'h00;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit [7:0] set, clr, req, np;
    int nc;
    bit nd, ovf, cmp;
    if (rst) begin
      m_flags = 0; m_mask = 0; m_pend = 0; m_cnt = 0; m_down = 0;
    end else begin
      nc = m_cnt; nd = t2_pwm ? m_down : 1'b0; ovf = 0;
      if (t2_tick) begin
        if (!t2_pwm) begin
          nc = (m_cnt + 1) % 256; ovf = (m_cnt == 255);
        end else if (!m_down) begin
          if (m_cnt == 255) begin nd = 1; nc = 254; end else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 0; nc = 1; ovf = 1; end else nc = m_cnt - 1;
        end
      end
      cmp = t2_tick && (nc == int'(t2_cmp));
      set = {cmp, ovf, evt_lo};
      clr = ((wr_en && !wr_sel) ? wr_data : 8'h00) | ack;
      req = gie ? (m_flags & m_mask) : 8'h00;
      if (m_pend != 0) np = ((ack & m_pend) != 0) ? 8'h00 : m_pend;
      else np = top_bit(req);
      m_flags = set | (m_flags & ~clr);
      if (wr_en && wr_sel) m_mask = wr_data;
      m_pend = np; m_cnt = nc; m_down = nd;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "flags", flags, m_flags);
      check(cur_req, "mask", mask, m_mask);
      check(cur_req, "pend", pend, m_pend);
      check(cur_req, "t2_count", t2_count, m_cnt);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    evt_lo = v; cyc(); evt_lo = '0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_ack(input logic [7:0] a);
    ack = a; cyc(); ack = '0;
  endtask

  task automatic ticks(input int n);
    t2_tick = 1'b1; cyc(n); t2_tick = 1'b0;
  endtask

  initial begin
    cyc(3);
    cmp_on = 1'b1;
    cur_req = "R1";
    check("R1", "flags", flags, 0); check("R1", "mask", mask, 0);
    check("R1", "pend", pend, 0);   check("R1", "t2_count", t2_count, 0);
    rst = 1'b0; cyc();

    cur_req = "R2";
    for (int b = 0; b < 6; b++) begin
      pulse_evt(6'(1 << b));
      check("R2", "flag bit set", flags[b], 1);
    end

    cur_req = "R3";
    wr(1'b0, 8'h00); check("R3", "zero write keeps", flags, 8'h3F);
    wr(1'b0, 8'h05); check("R3", "one write clears", flags, 8'h3A);
    wr(1'b0, 8'hFF); check("R3", "clear all", flags, 8'h00);

    cur_req = "R6";
    pulse_evt(6'h30);
    wr(1'b1, 8'hFF);
    check("R6", "mask load", mask, 8'hFF); check("R6", "flags untouched", flags, 8'h30);

    cur_req = "R7";
    cyc(2); check("R7", "gie off no pend", pend, 0);
    cur_req = "R8";
    gie = 1'b1; cyc(); check("R8", "highest first", pend, 8'h20);
    cur_req = "R4";
    do_ack(8'h20);
    check("R4", "ack clears flag", flags, 8'h10); check("R9", "pend drops on ack", pend, 0);
    cyc(); check("R8", "next source", pend, 8'h10);
    do_ack(8'h10); cyc();

    cur_req = "R9";
    pulse_evt(6'h01); cyc(); check("R9", "low pend", pend, 8'h01);
    pulse_evt(6'h20); cyc(2); check("R9", "held over higher", pend, 8'h01);
    do_ack(8'h01); cyc(); check("R9", "higher after ack", pend, 8'h20);
    do_ack(8'h20); cyc();

    cur_req = "R7";
    wr(1'b1, 8'h00); pulse_evt(6'h08); cyc(2);
    check("R7", "masked no pend", pend, 0);
    gie = 1'b0; wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);

    cur_req = "R5";
    evt_lo = 6'h04; wr(1'b0, 8'h04); evt_lo = '0;
    check("R5", "set beats write clear", flags[2], 1);
    evt_lo = 6'h02; do_ack(8'h02); evt_lo = '0;
    check("R5", "set beats ack", flags[1], 1);
    wr(1'b0, 8'hFF);

    cur_req = "R12";
    t2_pwm = 1'b0; t2_cmp = 8'h80;
    ticks(128);
    check("R12", "count at compare", t2_count, 8'h80);
    check("R12", "compare flag", flags[7], 1); check("R10", "no early wrap", flags[6], 0);
    cur_req = "R10";
    ticks(128);
    check("R10", "wrapped count", t2_count, 0); check("R10", "wrap flag", flags[6], 1);
    wr(1'b0, 8'hFF);

    cur_req = "R11";
    t2_pwm = 1'b1;
    ticks(255);
    check("R11", "top reached", t2_count, 8'hFF); check("R11", "no flag at top", flags[6], 0);
    ticks(255);
    check("R11", "down to zero", t2_count, 0); check("R11", "no flag arriving", flags[6], 0);
    ticks(1);
    check("R11", "reversal count", t2_count, 1); check("R11", "reversal flag", flags[6], 1);
    ticks(40);

    cur_req = "R1";
    t2_pwm = 1'b0; wr(1'b1, 8'hAA); pulse_evt(6'h15);
    rst = 1'b1; cyc(); rst = 1'b0;
    check("R1", "flags", flags, 0); check("R1", "mask", mask, 0);
    check("R1", "pend", pend, 0);   check("R1", "t2_count", t2_count, 0);
    cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule